// File: doc/BRIEF.md
# Compact 16-bit Control Processor Core

A small multi-cycle processor intended to sit inside a larger chip and run control firmware. Data words, registers and addresses are all 16 bits, so the core reaches a 64K-word space. Every access, instruction fetch included, goes through one word-addressed memory port. That port carries one request at a time and completes when the memory returns a ready strobe. The core has eight general-purpose registers. The program counter and the stack pointer are held apart from them, and no register field can name either one.

The instruction set has seven groups:
- arithmetic and logic with an optional small literal;
- a two-word load-immediate;
- word load and store through a base register plus a signed offset;
- a branch that tests a register directly;
- push and pop;
- call and return;
- a halt.

The core has no condition flags. A single carry bit is the only state kept between instructions, so that software can chain add and subtract across several words. When the core executes halt, or meets an encoding it does not recognise, it stops issuing requests and raises its halt output.

Top module: `ctl16_core`

## Requirements
- R1: After synchronous reset the PC is 0, SP is 0xFFFF, all eight registers and the carry are 0, halted and illegal are low, and the first request is a read of address 0.
- R2: Only one memory request is outstanding at a time. While mem_req is high and mem_ready is low, the address, write enable and write data hold steady. Read data is taken in the cycle mem_ready is high. Results do not depend on how many wait cycles the memory inserts.
- R3: The instruction word is laid out as follows. Bits 15:12 hold the opcode: 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 AND, 5 OR, 6 XOR, 7 LDI, 8 LD, 9 ST, A BR, B PUSH, C POP, D CALL, E RET, F system. Bits 11:9 name the destination or data register, bits 8:6 the source or base register, and bits 5:0 hold a field. In arithmetic and logic forms, field bit 5 set selects a literal in place of the source register, namely bits 4:0 zero-extended.
- R4: ADD and SUB ignore the incoming carry. ADD sets carry to the carry-out of bit 15. SUB sets carry to 1 when a borrow occurs.
- R5: ADC adds the carry in. SBB subtracts the carry as a borrow. Both update carry in the same way as ADD and SUB.
- R6: AND, OR and XOR write rd and leave the carry unchanged.
- R7: LDI loads rd with the word that follows the opcode word, and execution resumes after that second word.
- R8: LD and ST address memory at R[rs] plus the 6-bit field sign-extended. ST writes R[rd].
- R9: BR tests R[rs]. Bits 10:9 choose the condition: 0 zero, 1 nonzero, 2 negative, 3 non-negative. When the condition holds, the PC becomes the address of the next word plus the field sign-extended.
- R10: The stack grows downward. PUSH decrements SP and then writes R[rd] at SP. POP reads from SP into rd and then increments SP.
- R11: CALL pushes the address of the word after the CALL and jumps to R[rs] plus the field sign-extended. RET pops the PC.
- R12: The word 0xF000 halts the core with illegal low. Once halted, the core issues no further requests.
- R13: Any other word with opcode F halts the core and raises illegal. The core does not execute the instructions that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | A memory request is pending |
| mem_we | output | 1 | The pending request is a write |
| mem_addr | output | 16 | Word address of the request |
| mem_wdata | output | 16 | Data to write |
| mem_rdata | input | 16 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Completes the pending request this cycle |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an unrecognised encoding |

## Verification
Two situations are hard to reach from the ports: a carry that crosses instructions, and the stack. The carry must be set by an earlier instruction and read by a later one, and the stack contents only show up as memory traffic. Each arithmetic vector therefore becomes a short program. The program first forces the carry to a chosen value by adding a register to itself, then runs the operation, and finally copies the carry into a register with a literal ADC so that a store can expose it. The stack and call tests leave their pushed words in memory, and the bench reads them there. The bench memory also changes its number of wait cycles from program to program, so the same results are checked under stalls.

// File: rtl/ctl16_pkg.sv
`timescale 1ns/1ps
package ctl16_pkg;

    localparam int XLEN  = 16;
    localparam int OPC_W = 4;
    localparam int REG_W = 3;
    localparam int FLD_W = 6;
    localparam int LIT_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD  = 4'h0,
        OPC_ADC  = 4'h1,
        OPC_SUB  = 4'h2,
        OPC_SBB  = 4'h3,
        OPC_AND  = 4'h4,
        OPC_OR   = 4'h5,
        OPC_XOR  = 4'h6,
        OPC_LDI  = 4'h7,
        OPC_LD   = 4'h8,
        OPC_ST   = 4'h9,
        OPC_BR   = 4'hA,
        OPC_PUSH = 4'hB,
        OPC_POP  = 4'hC,
        OPC_CALL = 4'hD,
        OPC_RET  = 4'hE,
        OPC_SYS  = 4'hF
    } opc_t;

    typedef struct packed {
        opc_t               opc;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rs;
        logic [FLD_W-1:0]   fld;
    } insn_t;

    typedef enum logic [1:0] {
        CND_ZERO  = 2'd0,
        CND_NZERO = 2'd1,
        CND_NEG   = 2'd2,
        CND_NNEG  = 2'd3
    } cond_t;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_EXEC,
        ST_IMM,
        ST_LOAD,
        ST_STORE,
        ST_PUSH,
        ST_POP,
        ST_CALL,
        ST_RET,
        ST_HALT
    } state_t;

    function automatic logic [XLEN-1:0] sext_fld(input logic [FLD_W-1:0] f);
        return {{(XLEN-FLD_W){f[FLD_W-1]}}, f};
    endfunction

    function automatic logic [XLEN-1:0] zext_lit(input logic [LIT_W-1:0] l);
        return {{(XLEN-LIT_W){1'b0}}, l};
    endfunction

    function automatic logic is_alu(input opc_t o);
        return (o == OPC_ADD) || (o == OPC_ADC) || (o == OPC_SUB) || (o == OPC_SBB) ||
               (o == OPC_AND) || (o == OPC_OR)  || (o == OPC_XOR);
    endfunction

endpackage

// File: rtl/ctl16_alu.sv
`timescale 1ns/1ps
module ctl16_alu
    import ctl16_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  opc_t          op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] y,
    output logic          cout
);

    logic [DW:0] wide;
    logic        c_used;

    always_comb begin
        c_used = ((op == OPC_ADC) || (op == OPC_SBB)) ? cin : 1'b0;
        wide   = '0;
        y      = '0;
        cout   = cin;
        case (op)
            OPC_ADD, OPC_ADC: begin
                wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, c_used};
                y    = wide[DW-1:0];
                cout = wide[DW];
            end
            OPC_SUB, OPC_SBB: begin
                wide = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, c_used};
                y    = wide[DW-1:0];
                cout = wide[DW];
            end
            OPC_AND: y = a & b;
            OPC_OR:  y = a | b;
            OPC_XOR: y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/ctl16_cond.sv
`timescale 1ns/1ps
module ctl16_cond
    import ctl16_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  logic [DW-1:0] val,
    input  logic [1:0]    sel,
    output logic          take
);

    logic is_zero;
    logic is_neg;

    assign is_zero = (val == '0);
    assign is_neg  = val[DW-1];

    always_comb begin
        case (cond_t'(sel))
            CND_ZERO:  take = is_zero;
            CND_NZERO: take = !is_zero;
            CND_NEG:   take = is_neg;
            CND_NNEG:  take = !is_neg;
            default:   take = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctl16_regfile.sv
`timescale 1ns/1ps
module ctl16_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);

    logic [NREG-1:0][DW-1:0] view;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && (waddr == AW'(g))) begin
                q <= wdata;
            end
        end
        assign view[g] = q;
    end

    assign rdata_a = view[raddr_a];
    assign rdata_b = view[raddr_b];

endmodule

// File: rtl/ctl16_core.sv
`timescale 1ns/1ps
module ctl16_core
    import ctl16_pkg::*;
#(
    parameter int            DW     = XLEN,
    parameter int            NREG   = 8,
    parameter logic [DW-1:0] PC_RST = '0,
    parameter logic [DW-1:0] SP_RST = '1
) (
    input  logic          clk,
    input  logic          rst,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          halted,
    output logic          illegal
);

    localparam int RAW = $clog2(NREG);

    state_t        state;
    insn_t         ir;
    logic [DW-1:0] pc;
    logic [DW-1:0] sp;
    logic [DW-1:0] ea;
    logic          carry;
    logic          ill_q;

    logic [DW-1:0] rf_a;
    logic [DW-1:0] rf_b;
    logic          rf_we;
    logic [RAW-1:0] rf_wa;
    logic [DW-1:0] rf_wd;

    logic [DW-1:0] opnd_b;
    logic [DW-1:0] off;
    logic [DW-1:0] alu_y;
    logic          alu_c;
    logic          br_take;

    // operand selection: literal or register, plus signed field
    assign opnd_b = ir.fld[LIT_W] ? zext_lit(ir.fld[LIT_W-1:0]) : rf_b;
    assign off    = sext_fld(ir.fld);

    ctl16_regfile #(
        .DW   (DW),
        .NREG (NREG),
        .AW   (RAW)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (rf_wa),
        .wdata   (rf_wd),
        .raddr_a (RAW'(ir.rd)),
        .raddr_b (RAW'(ir.rs)),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    ctl16_alu #(
        .DW (DW)
    ) u_alu (
        .op   (ir.opc),
        .a    (rf_a),
        .b    (opnd_b),
        .cin  (carry),
        .y    (alu_y),
        .cout (alu_c)
    );

    ctl16_cond #(
        .DW (DW)
    ) u_cond (
        .val  (rf_b),
        .sel  (ir.rd[1:0]),
        .take (br_take)
    );

    // memory port driven from the current state
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = pc;
        mem_wdata = rf_a;
        case (state)
            ST_FETCH, ST_IMM: mem_addr = pc;
            ST_LOAD:          mem_addr = ea;
            ST_STORE: begin
                mem_addr = ea;
                mem_we   = 1'b1;
            end
            ST_PUSH: begin
                mem_addr = sp;
                mem_we   = 1'b1;
            end
            ST_POP, ST_RET:   mem_addr = sp;
            ST_CALL: begin
                mem_addr  = sp;
                mem_we    = 1'b1;
                mem_wdata = pc;
            end
            default:          mem_req = 1'b0;
        endcase
    end

    // register file write selection
    always_comb begin
        rf_we = 1'b0;
        rf_wa = RAW'(ir.rd);
        rf_wd = mem_rdata;
        case (state)
            ST_EXEC: begin
                if (is_alu(ir.opc)) begin
                    rf_we = 1'b1;
                    rf_wd = alu_y;
                end
            end
            ST_IMM, ST_LOAD, ST_POP: rf_we = mem_ready;
            default: rf_we = 1'b0;
        endcase
    end

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
            ir    <= '0;
            pc    <= PC_RST;
            sp    <= SP_RST;
            ea    <= '0;
            carry <= 1'b0;
            ill_q <= 1'b0;
        end else begin
            case (state)
                ST_FETCH: begin
                    if (mem_ready) begin
                        ir    <= insn_t'(mem_rdata);
                        pc    <= pc + DW'(1);
                        state <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    state <= ST_FETCH;
                    case (ir.opc)
                        OPC_ADD, OPC_ADC, OPC_SUB, OPC_SBB,
                        OPC_AND, OPC_OR, OPC_XOR: carry <= alu_c;
                        OPC_LDI: state <= ST_IMM;
                        OPC_LD: begin
                            ea    <= rf_b + off;
                            state <= ST_LOAD;
                        end
                        OPC_ST: begin
                            ea    <= rf_b + off;
                            state <= ST_STORE;
                        end
                        OPC_BR: begin
                            if (br_take) begin
                                pc <= pc + off;
                            end
                        end
                        OPC_PUSH: begin
                            sp    <= sp - DW'(1);
                            state <= ST_PUSH;
                        end
                        OPC_POP: state <= ST_POP;
                        OPC_CALL: begin
                            sp    <= sp - DW'(1);
                            ea    <= rf_b + off;
                            state <= ST_CALL;
                        end
                        OPC_RET: state <= ST_RET;
                        default: begin
                            state <= ST_HALT;
                            ill_q <= ({ir.rd, ir.rs, ir.fld} != '0);
                        end
                    endcase
                end
                ST_IMM: begin
                    if (mem_ready) begin
                        pc    <= pc + DW'(1);
                        state <= ST_FETCH;
                    end
                end
                ST_LOAD, ST_STORE, ST_PUSH: begin
                    if (mem_ready) begin
                        state <= ST_FETCH;
                    end
                end
                ST_POP: begin
                    if (mem_ready) begin
                        sp    <= sp + DW'(1);
                        state <= ST_FETCH;
                    end
                end
                ST_CALL: begin
                    if (mem_ready) begin
                        pc    <= ea;
                        state <= ST_FETCH;
                    end
                end
                ST_RET: begin
                    if (mem_ready) begin
                        pc    <= mem_rdata;
                        sp    <= sp + DW'(1);
                        state <= ST_FETCH;
                    end
                end
                ST_HALT: state <= ST_HALT;
                default: state <= ST_HALT;
            endcase
        end
    end

    assign halted  = (state == ST_HALT);
    assign illegal = ill_q;

endmodule

// File: rtl/ctl16_core_chk.sv
`timescale 1ns/1ps
module ctl16_core_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready,
    input logic          halted,
    input logic          illegal
);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2
    write_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    // R12
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R12
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_req);

    // R13
    illegal_halts_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted);

endmodule

bind ctl16_core ctl16_core_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .halted    (halted),
    .illegal   (illegal)
);

// File: tb/sim_ctl16_core.sv
`timescale 1ns/1ps
module sim_ctl16_core;

    localparam int DW    = 16;
    localparam int MW    = 10;
    localparam int HALF  = 10;
    localparam int NVEC  = 13;
    localparam int WDOG  = 150000;

    typedef struct packed {
        logic [3:0]  op;
        logic        imm;
        logic [15:0] a;
        logic [15:0] b;
        logic        cin;
        logic [15:0] res;
        logic        cout;
    } vec_t;

    // op, literal, a, b, carry in, result, carry out
    localparam vec_t VEC [NVEC] = '{
        '{4'h0, 1'b0, 16'h1234, 16'h1111, 1'b1, 16'h2345, 1'b0},
        '{4'h0, 1'b0, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1},
        '{4'h1, 1'b0, 16'h0001, 16'h0002, 1'b1, 16'h0004, 1'b0},
        '{4'h1, 1'b0, 16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1},
        '{4'h2, 1'b0, 16'h0005, 16'h0003, 1'b0, 16'h0002, 1'b0},
        '{4'h2, 1'b0, 16'h0003, 16'h0005, 1'b0, 16'hFFFE, 1'b1},
        '{4'h3, 1'b0, 16'h0005, 16'h0005, 1'b1, 16'hFFFF, 1'b1},
        '{4'h3, 1'b0, 16'h0010, 16'h0001, 1'b1, 16'h000E, 1'b0},
        '{4'h4, 1'b0, 16'hF0F0, 16'h3C3C, 1'b1, 16'h3030, 1'b1},
        '{4'h5, 1'b0, 16'hF000, 16'h000F, 1'b0, 16'hF00F, 1'b0},
        '{4'h6, 1'b0, 16'hFFFF, 16'h0F0F, 1'b1, 16'hF0F0, 1'b1},
        '{4'h0, 1'b1, 16'hFFF0, 16'h001F, 1'b1, 16'h000F, 1'b1},
        '{4'h2, 1'b1, 16'h0000, 16'h0001, 1'b0, 16'hFFFF, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mem_req;
    logic          mem_we;
    logic [DW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ready = 1'b0;
    logic          halted;
    logic          illegal;

    logic [DW-1:0] mem [0:(1<<MW)-1];
    int lat   = 0;
    int wcnt  = 0;
    int ptr   = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #HALF clk = ~clk;

    ctl16_core u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .halted    (halted),
        .illegal   (illegal)
    );

    // memory model with programmable wait cycles
    always @(negedge clk) begin
        if (rst) begin
            mem_ready = 1'b0;
            wcnt      = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                wcnt      = 0;
                mem_ready = 1'b1;
                if (mem_we) mem[mem_addr[MW-1:0]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[MW-1:0]];
            end else begin
                wcnt = wcnt + 1;
            end
        end
    end

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] rd,
                                        input logic [2:0] rs, input logic [5:0] f);
        return {op, rd, rs, f};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < (1<<MW); i++) mem[i] = '0;
        ptr = 0;
    endtask

    task automatic put(input logic [15:0] w);
        mem[ptr] = w;
        ptr = ptr + 1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 4000; i++) begin
            if (halted) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    function automatic string tag_of(input int i);
        string t;
        case (VEC[i].op)
            4'h0, 4'h2: t = "R4";
            4'h1, 4'h3: t = "R5";
            default:    t = "R6";
        endcase
        if (VEC[i].imm) t = {t, " R3"};
        return {t, " R2"};
    endfunction

    initial begin
        #(2 * HALF * WDOG);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog R2 actual=%0d expected=halt", WDOG);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // ---------------- arithmetic and logic table ----------------
        for (int i = 0; i < NVEC; i++) begin
            rst = 1'b1;
            clear_mem();
            lat = i % 3;
            put(enc(4'h7, 3'd1, 3'd0, 6'd0)); put(VEC[i].a);
            put(enc(4'h7, 3'd2, 3'd0, 6'd0)); put(VEC[i].b);
            put(enc(4'h7, 3'd3, 3'd0, 6'd0)); put(VEC[i].cin ? 16'h8000 : 16'h0000);
            put(enc(4'h0, 3'd3, 3'd3, 6'd0));
            if (VEC[i].imm) put(enc(VEC[i].op, 3'd1, 3'd0, {1'b1, VEC[i].b[4:0]}));
            else            put(enc(VEC[i].op, 3'd1, 3'd2, 6'd0));
            put(enc(4'h7, 3'd4, 3'd0, 6'd0)); put(16'h0100);
            put(enc(4'h9, 3'd1, 3'd4, 6'd0));
            put(enc(4'h7, 3'd5, 3'd0, 6'd0)); put(16'h0000);
            put(enc(4'h1, 3'd5, 3'd0, 6'b100000));
            put(enc(4'h9, 3'd5, 3'd4, 6'd1));
            put(16'hF000);
            do_reset();
            wait_halt();
            chk({tag_of(i), " result"}, mem[10'h100], VEC[i].res);
            chk({tag_of(i), " carry"},  mem[10'h101], {15'b0, VEC[i].cout});
        end
        // R12: plain halt word
        chk("R12 halted", {15'b0, halted}, 16'h0001);
        chk("R12 illegal low", {15'b0, illegal}, 16'h0000);
        chk("R12 no request", {15'b0, mem_req}, 16'h0000);

        // ---------------- branches (R9) ----------------
        rst = 1'b1;
        clear_mem();
        lat = 2;
        put(enc(4'h7, 3'd1, 3'd0, 6'd0)); put(16'h0000);
        put(enc(4'h7, 3'd2, 3'd0, 6'd0)); put(16'h8000);
        put(enc(4'h7, 3'd3, 3'd0, 6'd0)); put(16'h0005);
        put(enc(4'h7, 3'd6, 3'd0, 6'd0)); put(16'h0000);
        put(enc(4'hA, 3'd0, 3'd1, 6'd1)); put(enc(4'h5, 3'd6, 3'd0, 6'b100001));
        put(enc(4'hA, 3'd1, 3'd1, 6'd1)); put(enc(4'h5, 3'd6, 3'd0, 6'b100010));
        put(enc(4'hA, 3'd2, 3'd2, 6'd1)); put(enc(4'h5, 3'd6, 3'd0, 6'b100100));
        put(enc(4'hA, 3'd3, 3'd2, 6'd1)); put(enc(4'h5, 3'd6, 3'd0, 6'b101000));
        put(enc(4'hA, 3'd3, 3'd3, 6'd1)); put(enc(4'h5, 3'd6, 3'd0, 6'b110000));
        put(enc(4'hA, 3'd0, 3'd3, 6'd1)); put(enc(4'h5, 3'd6, 3'd0, 6'b110000));
        put(enc(4'h7, 3'd7, 3'd0, 6'd0)); put(16'h0003);
        put(enc(4'h7, 3'd5, 3'd0, 6'd0)); put(16'h0000);
        put(enc(4'h0, 3'd5, 3'd0, 6'b100001));
        put(enc(4'h2, 3'd7, 3'd0, 6'b100001));
        put(enc(4'hA, 3'd1, 3'd7, 6'b111101));
        put(enc(4'h7, 3'd4, 3'd0, 6'd0)); put(16'h0100);
        put(enc(4'h9, 3'd6, 3'd4, 6'd0));
        put(enc(4'h9, 3'd5, 3'd4, 6'd1));
        put(16'hF000);
        do_reset();
        wait_halt();
        chk("R9 condition mask", mem[10'h100], 16'h001A);
        chk("R9 backward loop count", mem[10'h101], 16'h0003);

        // ---------------- load/store and immediate (R8, R7) ----------------
        rst = 1'b1;
        clear_mem();
        lat = 0;
        mem[10'h100] = 16'hBEEF;
        put(enc(4'h7, 3'd1, 3'd0, 6'd0)); put(16'h0105);
        put(enc(4'h8, 3'd2, 3'd1, 6'b111011));
        put(enc(4'h9, 3'd2, 3'd1, 6'b111101));
        put(enc(4'h9, 3'd2, 3'd1, 6'b011111));
        put(enc(4'h7, 3'd3, 3'd0, 6'd0)); put(16'hC0DE);
        put(enc(4'h9, 3'd3, 3'd1, 6'd0));
        put(16'hF000);
        do_reset();
        wait_halt();
        chk("R8 negative offset", mem[10'h102], 16'hBEEF);
        chk("R8 positive offset", mem[10'h124], 16'hBEEF);
        chk("R7 second word", mem[10'h105], 16'hC0DE);

        // ---------------- stack, call, return (R10, R11) ----------------
        rst = 1'b1;
        clear_mem();
        lat = 1;
        put(enc(4'h7, 3'd1, 3'd0, 6'd0)); put(16'hAAAA);
        put(enc(4'h7, 3'd2, 3'd0, 6'd0)); put(16'h5555);
        put(enc(4'hB, 3'd1, 3'd0, 6'd0));
        put(enc(4'hB, 3'd2, 3'd0, 6'd0));
        put(enc(4'hC, 3'd3, 3'd0, 6'd0));
        put(enc(4'hC, 3'd4, 3'd0, 6'd0));
        put(enc(4'h7, 3'd5, 3'd0, 6'd0)); put(16'h0020);
        put(enc(4'hD, 3'd0, 3'd5, 6'd0));
        put(enc(4'h7, 3'd7, 3'd0, 6'd0)); put(16'h0100);
        put(enc(4'h9, 3'd3, 3'd7, 6'd0));
        put(enc(4'h9, 3'd4, 3'd7, 6'd1));
        put(enc(4'h9, 3'd1, 3'd7, 6'd2));
        put(16'hF000);
        mem[10'h020] = enc(4'h0, 3'd1, 3'd0, 6'b100001);
        mem[10'h021] = enc(4'hE, 3'd0, 3'd0, 6'd0);
        do_reset();
        wait_halt();
        chk("R10 pop order first", mem[10'h100], 16'h5555);
        chk("R10 pop order second", mem[10'h101], 16'hAAAA);
        chk("R10 second push slot", mem[10'h3FD], 16'h5555);
        chk("R11 subroutine ran and returned", mem[10'h102], 16'hAAAB);
        chk("R11 return address pushed", mem[10'h3FE], 16'h000B);

        // ---------------- reset state (R1) under wait cycles (R2) ----------------
        rst = 1'b1;
        clear_mem();
        lat = 3;
        mem[10'h100] = 16'hFFFF;
        mem[10'h101] = 16'hFFFF;
        mem[10'h102] = 16'hFFFF;
        put(enc(4'h7, 3'd4, 3'd0, 6'd0)); put(16'h0100);
        put(enc(4'h9, 3'd1, 3'd4, 6'd0));
        put(enc(4'h9, 3'd7, 3'd4, 6'd1));
        put(enc(4'h1, 3'd2, 3'd0, 6'b100000));
        put(enc(4'h9, 3'd2, 3'd4, 6'd2));
        put(16'hF000);
        do_reset();
        #1;
        chk("R1 first request", {15'b0, mem_req}, 16'h0001);
        chk("R1 fetch address", mem_addr, 16'h0000);
        chk("R1 read not write", {15'b0, mem_we}, 16'h0000);
        chk("R1 halted low", {15'b0, halted}, 16'h0000);
        chk("R1 illegal low", {15'b0, illegal}, 16'h0000);
        @(negedge clk);
        #1;
        chk("R2 request held", {15'b0, mem_req}, 16'h0001);
        chk("R2 address held", mem_addr, 16'h0000);
        wait_halt();
        chk("R1 register r1 cleared", mem[10'h100], 16'h0000);
        chk("R1 register r7 cleared", mem[10'h101], 16'h0000);
        chk("R1 carry cleared", mem[10'h102], 16'h0000);

        // ---------------- illegal encoding (R13) ----------------
        rst = 1'b1;
        clear_mem();
        lat = 0;
        mem[20] = 16'h7777;
        put(16'hF123);
        put(enc(4'h9, 3'd0, 3'd0, 6'd20));
        do_reset();
        wait_halt();
        repeat (4) @(negedge clk);
        chk("R13 halted", {15'b0, halted}, 16'h0001);
        chk("R13 illegal raised", {15'b0, illegal}, 16'h0001);
        chk("R13 no request", {15'b0, mem_req}, 16'h0000);
        chk("R13 next word not run", mem[20], 16'h7777);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule